// File: doc/BRIEF.md
# HDLC Frame Receiver with Header-Only FCS Option

This block takes a serial bit stream qualified by a bit-valid strobe and recovers HDLC frames from it. It hunts for the 0x7E flag and treats each flag as the boundary between frames. It drops the zero that a transmitter inserts after five ones. It assembles payload bytes least significant bit first. The last two or four bytes of each frame are held back so that they are never presented as payload. The held-back bytes are then compared with a locally computed frame check sequence.

In its default mode the check covers the whole payload. In truncated mode the running CRC stops after the first N payload bytes and keeps that value until the closing flag. Only a header region is protected, and the rest of the frame can carry errors without failing the check. A run of seven ones aborts the current frame. An idle indication shows when no frame data is in progress.

Top module: `hdlc_trunc_rx`

## Requirements
- R1: A 0x7E flag (zero, six ones, zero) opens and closes frames. Flags with no complete byte between them produce no byte strobe and no end-of-frame pulse, and `out_idle` stays high.
- R2: In the bit stream, a zero that follows five consecutive ones is removed before bytes are formed. Payloads of all 0xFF or all 0x7E come out unchanged.
- R3: Payload bytes are formed from the first received bit as bit 0. Each payload byte gives one `out_stb` pulse with the byte on `out_data`. The trailing 2 FCS bytes (when `fcs32_sel`=0) or 4 FCS bytes (when `fcs32_sel`=1) are never strobed.
- R4: When `fcs32_sel`=0, the check uses CRC-16 with polynomial x^16+x^12+x^5+1, in reflected form, with the register preset to 0xFFFF. The transmitted FCS is the one's complement of the register, sent low byte first.
- R5: When `fcs32_sel`=1, the check uses the IEEE 802.3 CRC-32 in reflected form, with the register preset to 0xFFFFFFFF. The transmitted FCS is the complement of the register, sent least significant byte first.
- R6: The closing flag of a frame that held at least one byte gives one `out_eof` pulse. `out_fcs_ok` is high in that same cycle only when the received FCS matches, and it is low when the FCS or any checked byte is corrupted.
- R7: When `trunc_en`=1, only the first N payload bytes enter the CRC. Later payload bytes may change without affecting `out_fcs_ok`, while a change within the first N bytes clears it.
- R8: N equals `trunc_cnt` when that field is 1 to 15, and N equals 16 when the field is 0.
- R9: In truncated mode, a frame with fewer than N payload bytes is checked over all of its payload.
- R10: Seven consecutive ones inside a frame give one `out_abort` pulse and no `out_eof` for that frame. `out_idle` is high from that cycle on until bytes of a new frame arrive.
- R11: After reset, `out_stb`, `out_eof`, `out_fcs_ok` and `out_abort` are low and `out_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial line bit |
| rx_valid | input | 1 | Qualifies `rx_bit` in this cycle |
| trunc_en | input | 1 | Limit the CRC to the first N payload bytes |
| trunc_cnt | input | 4 | N for truncated mode (0 means 16) |
| fcs32_sel | input | 1 | 1 selects a 32-bit FCS, 0 selects a 16-bit FCS |
| out_data | output | 8 | Payload byte |
| out_stb | output | 1 | One-cycle strobe for `out_data` |
| out_eof | output | 1 | One-cycle end-of-frame pulse |
| out_fcs_ok | output | 1 | FCS matched, valid with `out_eof` |
| out_abort | output | 1 | One-cycle pulse on an abort inside a frame |
| out_idle | output | 1 | High when no frame data is in progress |

## Verification
The assertions check the per-cycle relations on every cycle: a strobe never coincides with an end of frame, the FCS-good flag only appears with an end of frame, an abort never gives an end of frame and always raises idle, and a deleted stuffed zero never produces a byte strobe. Only the bench's scenarios can show that the values are right. These cover recovered payload contents through stuffing, the CRC-16 and CRC-32 results, the truncation window for different N including the zero encoding, short frames in truncated mode, and corruption placed inside and outside the protected header.

// File: rtl/hdlc_trunc_rx.sv
module hdlc_trunc_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  input  logic       rx_valid,
  input  logic       trunc_en,
  input  logic [3:0] trunc_cnt,
  input  logic       fcs32_sel,
  output logic [7:0] out_data,
  output logic       out_stb,
  output logic       out_eof,
  output logic       out_fcs_ok,
  output logic       out_abort,
  output logic       out_idle
);
  localparam logic [31:0] POLY32 = 32'hEDB88320;
  localparam logic [15:0] POLY16 = 16'h8408;

  logic [2:0]  ones;
  logic [7:0]  acc;
  logic [2:0]  bcnt;
  logic [31:0] dl;
  logic [2:0]  held;
  logic [4:0]  pcnt;
  logic [31:0] crc;
  logic        in_frame, got_byte;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d, input logic w32);
    logic [31:0] r;
    logic [15:0] s;
    r = c;
    s = c[15:0];
    for (int i = 0; i < 8; i++) begin
      if (w32) r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY32) : (r >> 1);
      else     s = (s[0] ^ d[i]) ? ((s >> 1) ^ POLY16) : (s >> 1);
    end
    return w32 ? r : {16'h0, s};
  endfunction

  wire [2:0]  depth     = fcs32_sel ? 3'd4 : 3'd2;
  wire [4:0]  lim       = (trunc_cnt == 4'd0) ? 5'd16 : {1'b0, trunc_cnt};
  wire        is_flag   = rx_valid && !rx_bit && ones == 3'd6;
  wire        is_abort  = rx_valid &&  rx_bit && ones == 3'd6;
  wire        is_stuff  = rx_valid && !rx_bit && ones == 3'd5;
  wire        is_data   = rx_valid && in_frame && !is_abort && !is_flag && !is_stuff;
  wire        byte_done = is_data && bcnt == 3'd7;
  wire [7:0]  new_byte  = {rx_bit, acc[7:1]};
  wire        pop       = byte_done && held == depth;
  wire [7:0]  pop_byte  = fcs32_sel ? dl[7:0] : dl[23:16];
  wire        crc_upd   = pop && (!trunc_en || pcnt < lim);
  wire [31:0] fcs_rx    = fcs32_sel ? dl : {16'h0, dl[31:16]};
  wire [31:0] fcs_exp   = fcs32_sel ? ~crc : {16'h0, ~crc[15:0]};
  wire        good      = bcnt == 3'd7 && held == depth && fcs_rx == fcs_exp;
  wire [31:0] crc_init  = fcs32_sel ? 32'hFFFFFFFF : 32'h0000FFFF;

  assign out_idle = !in_frame || !got_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones <= '0; acc <= '0; bcnt <= '0; dl <= '0; held <= '0; pcnt <= '0;
      crc <= '0; in_frame <= 1'b0; got_byte <= 1'b0;
      out_data <= '0; out_stb <= 1'b0; out_eof <= 1'b0;
      out_fcs_ok <= 1'b0; out_abort <= 1'b0;
    end else begin
      out_stb <= 1'b0; out_eof <= 1'b0; out_fcs_ok <= 1'b0; out_abort <= 1'b0;
      if (rx_valid) ones <= rx_bit ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
      if (is_abort) begin
        if (in_frame) out_abort <= 1'b1;
        in_frame <= 1'b0;
        got_byte <= 1'b0;
      end else if (is_flag) begin
        if (in_frame && got_byte) begin
          out_eof    <= 1'b1;
          out_fcs_ok <= good;
        end
        in_frame <= 1'b1; got_byte <= 1'b0;
        bcnt <= '0; held <= '0; pcnt <= '0; dl <= '0;
        crc <= crc_init;
      end else if (is_data) begin
        acc  <= new_byte;
        bcnt <= bcnt + 3'd1;
        if (byte_done) begin
          got_byte <= 1'b1;
          dl <= {new_byte, dl[31:8]};
          if (pop) begin
            out_data <= pop_byte;
            out_stb  <= 1'b1;
            if (pcnt != 5'd31) pcnt <= pcnt + 5'd1;
            if (crc_upd) crc <= crc_step(crc, pop_byte, fcs32_sel);
          end else begin
            held <= held + 3'd1;
          end
        end
      end
    end
  end

  a_r3_stb_not_eof: assert property (@(posedge clk) disable iff (!rst_n) !(out_stb && out_eof));
  a_r6_ok_with_eof: assert property (@(posedge clk) disable iff (!rst_n) out_fcs_ok |-> out_eof);
  a_r10_abort_no_eof: assert property (@(posedge clk) disable iff (!rst_n) out_abort |-> !out_eof);
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n) out_abort |-> out_idle);
  a_r2_stuff_no_byte: assert property (@(posedge clk) disable iff (!rst_n) is_stuff |=> !out_stb);
  a_r3_holdback_bound: assert property (@(posedge clk) disable iff (!rst_n) held <= depth);
endmodule

// File: tb/sim_hdlc_trunc_rx.sv
module sim_hdlc_trunc_rx;
  logic clk = 1'b0, rst_n = 1'b0, rx_bit = 1'b1, rx_valid = 1'b0;
  logic trunc_en = 1'b0, fcs32_sel = 1'b0;
  logic [3:0] trunc_cnt = 4'd0;
  logic [7:0] out_data;
  logic out_stb, out_eof, out_fcs_ok, out_abort, out_idle;

  int errors = 0, checks = 0;
  int gcnt = 0, eofs = 0, aborts = 0, tx_ones = 0;
  logic last_ok = 1'b0;
  logic [7:0] got [0:63];
  logic [7:0] pay [0:63];

  always #5 clk = ~clk;

  hdlc_trunc_rx u0 (.clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .trunc_en(trunc_en), .trunc_cnt(trunc_cnt), .fcs32_sel(fcs32_sel),
    .out_data(out_data), .out_stb(out_stb), .out_eof(out_eof),
    .out_fcs_ok(out_fcs_ok), .out_abort(out_abort), .out_idle(out_idle));

  always @(negedge clk) begin
    if (out_stb) begin if (gcnt < 64) got[gcnt] = out_data; gcnt++; end
    if (out_eof) begin eofs++; last_ok = out_fcs_ok; end
    if (out_abort) aborts++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [31:0] ref_crc(input int n, input bit w32);
    logic [31:0] c = w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ pay[k][i];
        c = c >> 1;
        if (fb) c = c ^ (w32 ? 32'hEDB88320 : 32'h00008408);
      end
    return c;
  endfunction

  task automatic raw(input logic b);
    @(negedge clk);
    rx_bit = b; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat ($urandom % 2) @(negedge clk);
  endtask

  task automatic dbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      raw(v[i]);
      tx_ones = v[i] ? tx_ones + 1 : 0;
      if (tx_ones == 5) begin raw(1'b0); tx_ones = 0; end
    end
  endtask

  task automatic flag();
    raw(1'b0); for (int i = 0; i < 6; i++) raw(1'b1); raw(1'b0);
    tx_ones = 0;
  endtask

  task automatic fill(input int len, input int pat);
    for (int i = 0; i < len; i++)
      pay[i] = (pat == 1) ? 8'hFF : (pat == 2) ? 8'h7E : 8'($urandom);
  endtask

  task automatic frame(input bit w32, input bit tr, input logic [3:0] cnt, input int len,
                       input int bad_idx, input bit bad_fcs, input bit exp_ok, input string req);
    int n, nf;
    logic [31:0] f;
    fcs32_sel = w32; trunc_en = tr; trunc_cnt = cnt;
    n = (cnt == 0) ? 16 : int'(cnt);
    n = (!tr || len < n) ? len : n;
    nf = w32 ? 4 : 2;
    f = ~ref_crc(n, w32);
    if (bad_fcs) f[3] = ~f[3];
    if (bad_idx >= 0) pay[bad_idx] = pay[bad_idx] ^ 8'h10;
    gcnt = 0; eofs = 0;
    flag();
    for (int i = 0; i < len; i++) dbyte(pay[i]);
    for (int i = 0; i < nf; i++) dbyte(f[8*i +: 8]);
    flag();
    repeat (4) @(negedge clk);
    chk(gcnt == len, "R3 byte count", gcnt, len);
    for (int i = 0; i < len && i < gcnt; i++)
      chk(got[i] == pay[i], "R2 R3 payload", got[i], pay[i]);
    chk(eofs == 1, "R6 eof count", eofs, 1);
    chk(last_ok == exp_ok, req, last_ok, exp_ok);
  endtask

  initial begin
    #1_500_000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!out_stb && !out_eof && !out_fcs_ok && !out_abort, "R11 outputs low", out_stb, 0);
    chk(out_idle == 1'b1, "R11 idle", out_idle, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    gcnt = 0; eofs = 0;
    repeat (5) flag();
    repeat (3) @(negedge clk);
    chk(gcnt == 0 && eofs == 0, "R1 back-to-back flags", gcnt + eofs, 0);
    chk(out_idle == 1'b1, "R1 idle between flags", out_idle, 1);

    fill(6, 1); frame(1'b0, 1'b0, 4'd0, 6, -1, 1'b0, 1'b1, "R2 all-ones payload");
    fill(6, 2); frame(1'b1, 1'b0, 4'd0, 6, -1, 1'b0, 1'b1, "R2 flag-valued payload");
    for (int k = 0; k < 6; k++) begin
      fill(1 + $urandom % 30, 0);
      frame(1'b0, 1'b0, 4'd0, 1 + $urandom % 30, -1, 1'b0, 1'b1, "R4 crc16 good");
    end
    for (int k = 0; k < 6; k++) begin
      fill(40, 0);
      frame(1'b1, 1'b0, 4'd0, 1 + $urandom % 30, -1, 1'b0, 1'b1, "R5 crc32 good");
    end
    fill(12, 0); frame(1'b0, 1'b0, 4'd0, 12, -1, 1'b1, 1'b0, "R6 bad fcs16");
    fill(12, 0); frame(1'b1, 1'b0, 4'd0, 12, 7, 1'b0, 1'b0, "R6 corrupt payload crc32");

    fill(20, 0); frame(1'b0, 1'b1, 4'd5, 20, 12, 1'b0, 1'b1, "R7 corruption past N ignored");
    fill(20, 0); frame(1'b1, 1'b1, 4'd5, 20, 4, 1'b0, 1'b0, "R7 corruption inside N");
    fill(20, 0); frame(1'b0, 1'b1, 4'd1, 20, 1, 1'b0, 1'b1, "R7 N=1 tail ignored");
    fill(24, 0); frame(1'b1, 1'b1, 4'd0, 24, 18, 1'b0, 1'b1, "R8 field 0 means 16, tail");
    fill(24, 0); frame(1'b0, 1'b1, 4'd0, 24, 15, 1'b0, 1'b0, "R8 field 0 means 16, byte 15");
    for (int k = 0; k < 4; k++) begin
      logic [3:0] c = 4'(1 + $urandom % 15);
      fill(30, 0);
      frame(k[0], 1'b1, c, int'(c) + 1 + $urandom % 8, 29, 1'b0, 1'b1, "R7 random N");
    end
    fill(5, 0); frame(1'b1, 1'b1, 4'd12, 5, -1, 1'b0, 1'b1, "R9 short frame in truncated mode");
    fill(3, 0); frame(1'b0, 1'b1, 4'd9, 3, 1, 1'b0, 1'b0, "R9 short frame corrupt");

    gcnt = 0; eofs = 0; aborts = 0;
    fcs32_sel = 1'b0; trunc_en = 1'b0;
    flag(); dbyte(8'h12); dbyte(8'h34); dbyte(8'h56);
    for (int i = 0; i < 8; i++) raw(1'b1);
    repeat (3) @(negedge clk);
    chk(aborts == 1, "R10 abort pulse", aborts, 1);
    chk(eofs == 0, "R10 no eof on abort", eofs, 0);
    chk(out_idle == 1'b1, "R10 idle after abort", out_idle, 1);
    fill(8, 0); frame(1'b0, 1'b0, 4'd0, 8, -1, 1'b0, 1'b1, "R10 recovery after abort");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule